// File: doc/BRIEF.md
# Complementary PWM Timer

This block is a 16-bit up-counting timer that makes a pulse-width modulated waveform and, when asked, the inverse of that waveform on a second pin. A prescaler divides the clock by a power of two, from 1 to 128. Each prescaled tick advances the counter. When the count equals the programmed reload value, the next tick returns it to 1 and a new period begins. A compare value sets the point inside each period where the output changes level. A polarity bit chooses which side of that point is driven high.

Software sets up the timer through a narrow write port. It writes the reload value, the compare value, a starting count and a control word that holds enable, polarity, dual mode and the prescale exponent. Reload and compare values written while the timer runs are held in shadow registers and only take effect at the next period boundary, so a period is never cut short. Writing a starting count other than 1 before enabling makes the first period a one-shot that runs from that count up to reload. A one-cycle interrupt pulse marks every period boundary. In dual mode the second pin, which is otherwise an input, is switched to drive the complement.

A three-state machine sequences the counter. OFF is the stopped state. FIRST is the opening period, which may start from a preloaded count. RUN covers every later period. The transitions are: OFF to FIRST when enable is set; FIRST to RUN on the first wrap; FIRST to OFF and RUN to OFF when enable is cleared.

Top module: `cpwm_timer`

## Requirements
- R1: Write addresses are 0 reload, 1 compare, 2 starting count and 3 control. The control word uses bit 0 for enable, bit 1 for polarity, bit 2 for dual mode and bits 6:4 for the prescale exponent N. After reset, reload is 0xFFFF, compare is 0, the count is 1 and control is 0, so pwm_out=0, compl_out=1, compl_oe=0 and irq=0.
- R2: With reload R of at least 2, the counter advances once every 2^N clocks. It sweeps 1 through R, and on the tick after R it returns to 1. A full period therefore lasts R*2^N clocks.
- R3: While running with polarity 0, pwm_out is high when count > compare, which gives (R-P)*2^N high clocks per period for compare value P. With polarity 1, pwm_out is high when count <= compare, which gives P*2^N high clocks.
- R4: A starting count S written while stopped makes the first period run from S up to R. Every later period starts from 1.
- R5: compl_out is always the inverse of pwm_out. compl_oe is 1 exactly while the dual-mode bit is 1.
- R6: A reload or compare write made while running changes nothing in the period in progress. It applies from the next period boundary. While stopped, such a write applies one cycle later.
- R7: irq is high for exactly the one cycle in which the counter has just returned to 1 from R.
- R8: When enable is 0, pwm_out equals the polarity bit, the prescaler is cleared and the count is frozen. A starting-count write is ignored unless the timer has been stopped for at least one full cycle.
- R9: When enable is written at clock edge e, pwm_out follows the compare rule from edge e+1 onward. The first count advance happens at edge e+1+2^N, so from start S (N=0) irq first rises R-S+2 edges after e.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 16 | Write data |
| pwm_out | output | 1 | Main PWM output |
| compl_out | output | 1 | Complement of pwm_out |
| compl_oe | output | 1 | Drive enable for the complement pin (dual mode) |
| irq | output | 1 | One-cycle pulse at each period boundary |

## Verification
The assertions assume that the reload value is at least 2 while running, so that a wrap and its irq pulse never fall on back-to-back ticks. They also assume that software writes only mapped addresses. The stimulus keeps every reload value between 6 and 10 and changes the prescale exponent only between whole periods. It waits one idle cycle after clearing enable before it preloads a count, so every case it drives stays inside those assumptions.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_FIRST = 2'd1,
        ST_RUN   = 2'd2
    } cpwm_state_e;

    typedef enum logic [1:0] {
        A_RELOAD = 2'd0,
        A_CMP    = 2'd1,
        A_START  = 2'd2,
        A_CTRL   = 2'd3
    } cpwm_addr_e;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_POL_BIT  = 1;
    localparam int CTRL_DUAL_BIT = 2;
    localparam int CTRL_PS_LSB   = 4;

endpackage

// File: rtl/cpwm_regs.sv
module cpwm_regs
    import cpwm_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int PS_W   = 3,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  rel_sh,
    output logic [CNT_W-1:0]  cmp_sh,
    output logic              en,
    output logic              pol,
    output logic              dual,
    output logic [PS_W-1:0]   ps_sel,
    output logic              start_ld
);

    logic sel_rel, sel_cmp, sel_ctrl;

    always_comb begin
        sel_rel  = wr_en && (wr_addr == ADDR_W'(A_RELOAD));
        sel_cmp  = wr_en && (wr_addr == ADDR_W'(A_CMP));
        sel_ctrl = wr_en && (wr_addr == ADDR_W'(A_CTRL));
        start_ld = wr_en && (wr_addr == ADDR_W'(A_START));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rel_sh <= '1;
            cmp_sh <= '0;
        end else begin
            if (sel_rel) rel_sh <= wr_data;
            if (sel_cmp) cmp_sh <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en     <= 1'b0;
            pol    <= 1'b0;
            dual   <= 1'b0;
            ps_sel <= '0;
        end else if (sel_ctrl) begin
            en     <= wr_data[CTRL_EN_BIT];
            pol    <= wr_data[CTRL_POL_BIT];
            dual   <= wr_data[CTRL_DUAL_BIT];
            ps_sel <= wr_data[CTRL_PS_LSB +: PS_W];
        end
    end

endmodule

// File: rtl/cpwm_prescaler.sv
module cpwm_prescaler #(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [PS_W-1:0] ps_sel,
    output logic            tick
);

    localparam int PC_W = (1 << PS_W) - 1;

    logic [PC_W-1:0] pcnt_q;
    logic [PC_W-1:0] lim;

    always_comb begin
        lim  = PC_W'((1 << ps_sel) - 1);
        tick = run && (pcnt_q == lim);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt_q <= '0;
        end else if (!run || tick) begin
            pcnt_q <= '0;
        end else begin
            pcnt_q <= pcnt_q + 1'b1;
        end
    end

    AST_PRESC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (pcnt_q == '0)); // R8

endmodule

// File: rtl/cpwm_core.sv
module cpwm_core
    import cpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             start_ld,
    input  logic [CNT_W-1:0] start_val,
    input  logic [CNT_W-1:0] rel_sh,
    input  logic [CNT_W-1:0] cmp_sh,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cmp_act,
    output logic             run,
    output logic             irq
);

    localparam logic [CNT_W-1:0] CNT_FIRST = CNT_W'(1);

    cpwm_state_e     state_q, state_d;
    logic [CNT_W-1:0] cnt_q, rel_act, cmp_q;
    logic            irq_q;
    logic            wrap, off, load_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        off     = (state_q == ST_OFF);
        run     = en && !off;
        wrap    = tick && (cnt_q == rel_act);
        load_ok = off && start_ld;
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   if (en) state_d = ST_FIRST;
            ST_FIRST: begin
                if (!en)       state_d = ST_OFF;
                else if (wrap) state_d = ST_RUN;
            end
            ST_RUN:   if (!en) state_d = ST_OFF;
            default:  state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_FIRST;
        end else if (load_ok) begin
            cnt_q <= start_val;
        end else if (wrap) begin
            cnt_q <= CNT_FIRST;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rel_act <= '1;
            cmp_q   <= '0;
        end else if (off || wrap) begin
            rel_act <= rel_sh;
            cmp_q   <= cmp_sh;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= wrap;
    end

    assign cnt     = cnt_q;
    assign cmp_act = cmp_q;
    assign irq     = irq_q;

    AST_WRAP_TO_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt_q == CNT_FIRST)); // R2

    AST_IRQ_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> (cnt_q == CNT_FIRST)); // R7

    AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!off && !wrap) |=> ($stable(rel_act) && $stable(cmp_q))); // R6

    AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load_ok) |=> $stable(cnt_q)); // R8

endmodule

// File: rtl/cpwm_outstage.sv
module cpwm_outstage #(
    parameter int CNT_W = 16
) (
    input  logic             run,
    input  logic             pol,
    input  logic             dual,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    output logic             pwm_out,
    output logic             compl_out,
    output logic             compl_oe
);

    logic past_cmp, level;

    always_comb begin
        past_cmp  = (cnt > cmp);
        level     = pol ? !past_cmp : past_cmp;
        pwm_out   = run ? level : pol;
        compl_out = !pwm_out;
        compl_oe  = dual;
    end

endmodule

// File: rtl/cpwm_timer.sv
module cpwm_timer #(
    parameter int CNT_W  = 16,
    parameter int PS_W   = 3,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic              pwm_out,
    output logic              compl_out,
    output logic              compl_oe,
    output logic              irq
);

    logic [CNT_W-1:0] rel_sh, cmp_sh, cnt, cmp_act;
    logic [PS_W-1:0]  ps_sel;
    logic             en, pol, dual, start_ld, tick, run;

    cpwm_regs #(.CNT_W(CNT_W), .PS_W(PS_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rel_sh(rel_sh), .cmp_sh(cmp_sh), .en(en),
        .pol(pol), .dual(dual), .ps_sel(ps_sel), .start_ld(start_ld)
    );

    cpwm_prescaler #(.PS_W(PS_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .run(run), .ps_sel(ps_sel), .tick(tick)
    );

    cpwm_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .start_ld(start_ld),
        .start_val(wr_data), .rel_sh(rel_sh), .cmp_sh(cmp_sh), .cnt(cnt),
        .cmp_act(cmp_act), .run(run), .irq(irq)
    );

    cpwm_outstage #(.CNT_W(CNT_W)) u_out (
        .run(run), .pol(pol), .dual(dual), .cnt(cnt), .cmp(cmp_act),
        .pwm_out(pwm_out), .compl_out(compl_out), .compl_oe(compl_oe)
    );

    AST_IDLE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !irq) |=> !irq); // R8

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (pwm_out == pol)); // R8

endmodule

// File: tb/cpwm_timer_bench.sv
module cpwm_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        pwm_out, compl_out, compl_oe, irq;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cpwm_timer u_cpwm_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_out(pwm_out), .compl_out(compl_out),
        .compl_oe(compl_oe), .irq(irq)
    );

    // behavioural reference
    bit          m_en, m_pol, m_dual, m_irq;
    int          m_ps, m_pc, m_state;
    logic [15:0] m_rel_sh, m_cmp_sh, m_rel, m_cmp, m_cnt;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_pol = 0; m_dual = 0; m_irq = 0; m_ps = 0; m_pc = 0;
            m_state = 0; m_rel_sh = 16'hFFFF; m_cmp_sh = 0;
            m_rel = 16'hFFFF; m_cmp = 0; m_cnt = 1;
        end else begin
            bit running, tk, wr;
            running = m_en && (m_state != 0);
            tk = running && (m_pc == (1 << m_ps) - 1);
            wr = tk && (m_cnt == m_rel);
            m_irq = wr;
            if (m_state == 0 && wr_en && wr_addr == 2'd2) m_cnt = wr_data;
            else if (wr) m_cnt = 16'd1;
            else if (tk) m_cnt = m_cnt + 16'd1;
            if (!running || tk) m_pc = 0; else m_pc = m_pc + 1;
            if (m_state == 0 || wr) begin
                m_rel = m_rel_sh;
                m_cmp = m_cmp_sh;
            end
            case (m_state)
                0: if (m_en) m_state = 1;
                1: if (!m_en) m_state = 0; else if (wr) m_state = 2;
                default: if (!m_en) m_state = 0;
            endcase
            if (wr_en) begin
                case (wr_addr)
                    2'd0: m_rel_sh = wr_data;
                    2'd1: m_cmp_sh = wr_data;
                    2'd3: begin
                        m_en = wr_data[0]; m_pol = wr_data[1];
                        m_dual = wr_data[2]; m_ps = int'(wr_data[6:4]);
                    end
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit e_pwm;
            e_pwm = (m_en && m_state != 0) ? (m_pol ? (m_cnt <= m_cmp) : (m_cnt > m_cmp)) : m_pol;
            chk(pwm_out == e_pwm, "R3 pwm_out", int'(pwm_out), int'(e_pwm));
            chk(compl_out == !e_pwm, "R5 compl_out", int'(compl_out), int'(!e_pwm));
            chk(compl_oe == m_dual, "R5 compl_oe", int'(compl_oe), int'(m_dual));
            chk(irq == m_irq, "R7 irq", int'(irq), int'(m_irq));
        end
    end

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_addr = a; wr_data = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_irq();
        int t;
        t = 0;
        while (!irq && t < 5000) begin @(negedge clk); t++; end
    endtask

    task automatic measure(input int exp_per, input int exp_hi, input string tag);
        int per, hi;
        wait_irq();
        per = 0; hi = 0;
        do begin
            hi += int'(pwm_out);
            @(negedge clk);
            per++;
        end while (!irq && per < 5000);
        chk(per == exp_per, {tag, " period"}, per, exp_per);
        chk(hi == exp_hi, {tag, " high time"}, hi, exp_hi);
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        int k;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(pwm_out == 1'b0, "R1 reset pwm_out", int'(pwm_out), 0);
        chk(compl_out == 1'b1, "R1 reset compl_out", int'(compl_out), 1);
        chk(compl_oe == 1'b0, "R1 reset compl_oe", int'(compl_oe), 0);
        chk(irq == 1'b0, "R1 reset irq", int'(irq), 0);
        rst_n = 1'b1;
        idle(2);

        // R2 R3 R7: polarity 0, N=0, R=10, P=3
        wr(2'd0, 16'd10);
        wr(2'd1, 16'd3);
        wr(2'd3, 16'h0001);
        measure(10, 7, "R2 R3 pol0");

        // R8: stopped holds idle level
        wr(2'd3, 16'h0000);
        for (int i = 0; i < 15; i++) begin
            chk(pwm_out == 1'b0 && irq == 1'b0, "R8 stopped", int'(pwm_out), 0);
            @(negedge clk);
        end

        // R3: polarity 1
        wr(2'd3, 16'h0003);
        measure(10, 3, "R3 pol1");

        // R2: prescale N=2
        wr(2'd3, 16'h0023);
        measure(40, 12, "R2 presc");

        // R5: dual mode
        wr(2'd3, 16'h0027);
        chk(compl_oe == 1'b1, "R5 dual oe", int'(compl_oe), 1);

        // R8: start-count write while running is ignored
        wr(2'd2, 16'd5);
        measure(40, 12, "R8 ignored start");

        // R6: reload change mid-period
        wait_irq();
        wr(2'd0, 16'd6);
        k = 1;
        while (!irq && k < 5000) begin @(negedge clk); k++; end
        chk(k == 40, "R6 old period kept", k, 40);
        measure(24, 12, "R6 new reload");

        // R4 R9: one-shot first period from start count 7
        wr(2'd3, 16'h0004);
        idle(1);
        wr(2'd2, 16'd7);
        wr(2'd0, 16'd10);
        idle(1);
        wr_addr = 2'd3; wr_data = 16'h0005; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        k = 0;
        while (!irq && k < 5000) begin @(posedge clk); k++; @(negedge clk); end
        chk(k == 5, "R4 R9 one-shot first irq", k, 5);
        measure(10, 7, "R4 later periods");

        // R8: disable again, irq stays low
        wr(2'd3, 16'h0006);
        for (int i = 0; i < 12; i++) begin
            chk(pwm_out == 1'b1 && irq == 1'b0, "R8 idle pol1", int'(pwm_out), 1);
            @(negedge clk);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule